// File: doc/BRIEF.md
# Byte-Addressed Control Register Bank with Interrupt Combiner

This block is the system control register bank of a peripheral controller. It sits on a byte-wide host bus. Each access carries an 8-bit offset and moves exactly one byte. Registers that are 8, 16 or 32 bits wide are all reached through consecutive byte offsets, least significant byte first. A write to one byte of a wide register changes only that byte.

The bank also gathers up to eight peripheral interrupt lines into a sticky status register. It gates the status register with a mask register and drives one combined interrupt to the host. By convention, source 0 is the NAND controller, 1 is the MMC controller, 2 is the USB host, 3 is the serial port and 4 is the framebuffer. The clock-control, PLL, routing, function-enable and mode values are only stored, and they are presented on configuration outputs for the rest of the chip.

Offsets that map to no register return zero on a read and ignore a write. Either kind of access raises a one-cycle error flag.

Top module: `ctl_regbank`

## Requirements
- R1: Read data is registered. `bus_rdata` shows the addressed byte in the cycle after a read access (`bus_sel`=1, `bus_wr`=0), and shows 0x00 after any cycle that is not a read.
- R2: The 16-bit registers use little-endian byte lanes: clock control at 0x98/0x99, second PLL control at 0x9A/0x9B, and mode control at 0xE4/0xE5. The low byte is at the lower offset, and each register appears on its configuration output.
- R3: The 32-bit first PLL control register holds byte k at offset 0x9C+k, for k = 0 to 3. Byte k drives bits 8k+7:8k of `cfg_pll_a`.
- R4: A write to one byte lane of a multi-byte register leaves every other lane of that register unchanged.
- R5: The 8-bit registers at 0x52 (interrupt mask), 0x54 (interrupt routing) and 0xE0 (function enable) read back the last value written.
- R6: Offset 0x08 reads the parameter `REV_ID`. A write to 0x08 changes nothing and does not raise the error flag.
- R7: When source line i is high in a cycle, status bit i (offset 0x50) is set from the next cycle on. A source line that goes low does not clear the bit.
- R8: A write to 0x50 loads each status bit with the written bit. A source that is high in the same cycle keeps its bit set.
- R9: `host_irq` is high exactly when the bitwise AND of the status and mask registers is nonzero.
- R10: A read of an unmapped offset returns 0x00. A write to an unmapped offset changes no register. Both kinds of access pulse `bad_access` high for one cycle, in the cycle after the access.
- R11: A synchronous reset clears every stored register, `bus_rdata`, `bad_access` and `host_irq` to zero. After reset, offset 0x08 still reads `REV_ID`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| bad_access | output | 1 | One-cycle pulse after an access to an unmapped offset |
| irq_src | input | NUM_SRC | Peripheral interrupt lines, active high |
| host_irq | output | 1 | Combined interrupt to the host |
| cfg_clk_ctl | output | 8*CLK_CTL_BYTES | Stored clock control |
| cfg_pll_b | output | 8*PLL_B_BYTES | Stored second PLL control |
| cfg_pll_a | output | 8*PLL_A_BYTES | Stored first PLL control |
| cfg_func_en | output | 8 | Stored function enable |
| cfg_mode | output | 8*MODE_BYTES | Stored mode control |
| cfg_irq_route | output | 8 | Stored interrupt routing |

## Verification
The bench rewrites one byte lane of the 32-bit register after all four lanes are loaded. A design that merged lanes wrongly would corrupt a neighbouring byte, and the four read-backs would show it. It clears a status bit while its source is still high, and it writes a 1 into a status bit whose source is idle. A design that let the clear win, or that only accepted zeros, would report a wrong status and a wrong `host_irq`. It also accesses the odd gaps next to the interrupt registers, the ends of the offset space and the offset just past the PLL block. A loose decoder would return stale data there, change a register, or miss the error pulse. Finally, it resets the block in mid-run and reads back the wide registers and the revision byte.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;
   // Register offsets. The interrupt and PLL offsets are kept fixed because
   // software and the lane ordering depend on them.
   localparam logic [7:0] OFS_REVID     = 8'h08;
   localparam logic [7:0] OFS_IRQ_STAT  = 8'h50;
   localparam logic [7:0] OFS_IRQ_MASK  = 8'h52;
   localparam logic [7:0] OFS_IRQ_ROUTE = 8'h54;
   localparam logic [7:0] OFS_CLK_CTL   = 8'h98;
   localparam logic [7:0] OFS_PLL_B     = 8'h9A;
   localparam logic [7:0] OFS_PLL_A     = 8'h9C;
   localparam logic [7:0] OFS_FUNC_EN   = 8'hE0;
   localparam logic [7:0] OFS_MODE      = 8'hE4;

   // Conventional interrupt source positions.
   localparam int SRC_NAND   = 0;
   localparam int SRC_MMC    = 1;
   localparam int SRC_USBH   = 2;
   localparam int SRC_SERIAL = 3;
   localparam int SRC_FB     = 4;

   localparam int LANE_W = 8;
   localparam int NUM_LANE_REGS = 6;
endpackage

// File: rtl/regbank_lanes.sv
module regbank_lanes #(
   parameter int         NBYTES = 2,
   parameter logic [7:0] BASE   = 8'h00
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  wr_en,
   input  logic [7:0]            addr,
   input  logic [7:0]            wdata,
   output logic                  hit,
   output logic [7:0]            rbyte,
   output logic [8*NBYTES-1:0]   value
);
   logic [NBYTES-1:0] lane_hit;

   for (genvar k = 0; k < NBYTES; k++) begin : g_lane
      assign lane_hit[k] = (addr == BASE + 8'(k));

      always_ff @(posedge clk) begin
         if (rst)
            value[8*k +: 8] <= '0;
         else if (wr_en && lane_hit[k])
            value[8*k +: 8] <= wdata;
      end

      // A write aimed at another lane must not disturb this one.
      assert_lane_hold_R4: assert property (@(posedge clk) disable iff (rst)
         (wr_en && !lane_hit[k]) |=> $stable(value[8*k +: 8]));
   end

   assign hit = |lane_hit;

   always_comb begin
      rbyte = '0;
      for (int k = 0; k < NBYTES; k++)
         if (lane_hit[k]) rbyte = rbyte | value[8*k +: 8];
   end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
   parameter int NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               stat_wr,
   input  logic [7:0]         wdata,
   input  logic [NUM_SRC-1:0] src,
   input  logic [7:0]         mask,
   output logic [7:0]         status,
   output logic               irq
);
   for (genvar k = 0; k < 8; k++) begin : g_bit
      if (k < NUM_SRC) begin : g_live
         always_ff @(posedge clk) begin
            if (rst)
               status[k] <= 1'b0;
            else if (stat_wr)
               status[k] <= wdata[k] | src[k];
            else
               status[k] <= status[k] | src[k];
         end

         assert_src_sets_R7: assert property (@(posedge clk) disable iff (rst)
            src[k] |=> status[k]);
         assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
            (status[k] && !stat_wr) |=> status[k]);
      end else begin : g_tied
         assign status[k] = 1'b0;
      end
   end

   assign irq = |(status & mask);

   assert_mask_gate_R9: assert property (@(posedge clk) disable iff (rst)
      (mask == 8'h00) |-> !irq);
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
   import ctl_regbank_pkg::*;
#(
   parameter int         NUM_SRC       = 8,
   parameter logic [7:0] REV_ID        = 8'h3A,
   parameter int         CLK_CTL_BYTES = 2,
   parameter int         PLL_B_BYTES   = 2,
   parameter int         PLL_A_BYTES   = 4,
   parameter int         MODE_BYTES    = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       bus_sel,
   input  logic                       bus_wr,
   input  logic [7:0]                 bus_addr,
   input  logic [7:0]                 bus_wdata,
   output logic [7:0]                 bus_rdata,
   output logic                       bad_access,
   input  logic [NUM_SRC-1:0]         irq_src,
   output logic                       host_irq,
   output logic [8*CLK_CTL_BYTES-1:0] cfg_clk_ctl,
   output logic [8*PLL_B_BYTES-1:0]   cfg_pll_b,
   output logic [8*PLL_A_BYTES-1:0]   cfg_pll_a,
   output logic [7:0]                 cfg_func_en,
   output logic [8*MODE_BYTES-1:0]    cfg_mode,
   output logic [7:0]                 cfg_irq_route
);
   // Elaboration-time checks: wide registers must not run into their neighbours.
   if (NUM_SRC < 1 || NUM_SRC > 8) begin : g_chk_src
      $error("NUM_SRC must be 1..8");
   end
   if (CLK_CTL_BYTES < 1 || CLK_CTL_BYTES > 2) begin : g_chk_clk
      $error("CLK_CTL_BYTES must be 1..2");
   end
   if (PLL_B_BYTES < 1 || PLL_B_BYTES > 2) begin : g_chk_pllb
      $error("PLL_B_BYTES must be 1..2");
   end
   if (PLL_A_BYTES < 1 || PLL_A_BYTES > 4) begin : g_chk_plla
      $error("PLL_A_BYTES must be 1..4");
   end
   if (MODE_BYTES < 1 || MODE_BYTES > 4) begin : g_chk_mode
      $error("MODE_BYTES must be 1..4");
   end

   logic                     wr_any, rd_any;
   logic                     stat_hit, rev_hit, mapped;
   logic [NUM_LANE_REGS-1:0] hit;
   logic [7:0]               rb [NUM_LANE_REGS];
   logic [7:0]               mask_q, status_q, rsel;
   logic [7:0]               rdata_q;
   logic                     bad_q;

   assign wr_any = bus_sel &&  bus_wr;
   assign rd_any = bus_sel && !bus_wr;

   regbank_lanes #(.NBYTES(1), .BASE(OFS_IRQ_MASK)) u_mask (
      .clk(clk), .rst(rst), .wr_en(wr_any), .addr(bus_addr), .wdata(bus_wdata),
      .hit(hit[0]), .rbyte(rb[0]), .value(mask_q));
   regbank_lanes #(.NBYTES(1), .BASE(OFS_IRQ_ROUTE)) u_route (
      .clk(clk), .rst(rst), .wr_en(wr_any), .addr(bus_addr), .wdata(bus_wdata),
      .hit(hit[1]), .rbyte(rb[1]), .value(cfg_irq_route));
   regbank_lanes #(.NBYTES(CLK_CTL_BYTES), .BASE(OFS_CLK_CTL)) u_clk (
      .clk(clk), .rst(rst), .wr_en(wr_any), .addr(bus_addr), .wdata(bus_wdata),
      .hit(hit[2]), .rbyte(rb[2]), .value(cfg_clk_ctl));
   regbank_lanes #(.NBYTES(PLL_B_BYTES), .BASE(OFS_PLL_B)) u_pllb (
      .clk(clk), .rst(rst), .wr_en(wr_any), .addr(bus_addr), .wdata(bus_wdata),
      .hit(hit[3]), .rbyte(rb[3]), .value(cfg_pll_b));
   regbank_lanes #(.NBYTES(PLL_A_BYTES), .BASE(OFS_PLL_A)) u_plla (
      .clk(clk), .rst(rst), .wr_en(wr_any), .addr(bus_addr), .wdata(bus_wdata),
      .hit(hit[4]), .rbyte(rb[4]), .value(cfg_pll_a));
   regbank_lanes #(.NBYTES(1), .BASE(OFS_FUNC_EN)) u_fen (
      .clk(clk), .rst(rst), .wr_en(wr_any), .addr(bus_addr), .wdata(bus_wdata),
      .hit(hit[5]), .rbyte(rb[5]), .value(cfg_func_en));

   // The mode register sits alone in its own instance so MODE_BYTES stays independent.
   logic       mode_hit;
   logic [7:0] mode_rb;
   regbank_lanes #(.NBYTES(MODE_BYTES), .BASE(OFS_MODE)) u_mode (
      .clk(clk), .rst(rst), .wr_en(wr_any), .addr(bus_addr), .wdata(bus_wdata),
      .hit(mode_hit), .rbyte(mode_rb), .value(cfg_mode));

   assign stat_hit = (bus_addr == OFS_IRQ_STAT);
   assign rev_hit  = (bus_addr == OFS_REVID);

   irq_combiner #(.NUM_SRC(NUM_SRC)) u_irq (
      .clk(clk), .rst(rst), .stat_wr(wr_any && stat_hit), .wdata(bus_wdata),
      .src(irq_src), .mask(mask_q), .status(status_q), .irq(host_irq));

   assign mapped = (|hit) || mode_hit || stat_hit || rev_hit;

   always_comb begin
      rsel = mode_rb;
      for (int i = 0; i < NUM_LANE_REGS; i++) rsel = rsel | rb[i];
      if (stat_hit) rsel = rsel | status_q;
      if (rev_hit)  rsel = rsel | REV_ID;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata_q <= '0;
         bad_q   <= 1'b0;
      end else begin
         rdata_q <= rd_any ? rsel : 8'h00;
         bad_q   <= bus_sel && !mapped;
      end
   end

   assign bus_rdata  = rdata_q;
   assign bad_access = bad_q;

   assert_idle_rdata_R1: assert property (@(posedge clk) disable iff (rst)
      !rd_any |=> (bus_rdata == 8'h00));
   assert_revid_R6: assert property (@(posedge clk) disable iff (rst)
      (rd_any && bus_addr == OFS_REVID) |=> (bus_rdata == REV_ID));
   assert_bad_needs_access_R10: assert property (@(posedge clk) disable iff (rst)
      !bus_sel |=> !bad_access);
   assert_bad_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
      (bad_access && !$past(bus_wr)) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/test_ctl_regbank.sv
module test_ctl_regbank;
   localparam logic [7:0] REV = 8'h3A;

   logic       clk = 1'b0, rst = 1'b1, sel = 1'b0, wr = 1'b0;
   logic [7:0] addr = '0, wdata = '0, src = '0;
   logic [7:0] rdata, route, fen;
   logic       bad, irq;
   logic [15:0] clkc, pllb, mode;
   logic [31:0] plla;

   ctl_regbank #(.NUM_SRC(8), .REV_ID(REV)) i_ctl_regbank (
      .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .bad_access(bad), .irq_src(src),
      .host_irq(irq), .cfg_clk_ctl(clkc), .cfg_pll_b(pllb), .cfg_pll_a(plla),
      .cfg_func_en(fen), .cfg_mode(mode), .cfg_irq_route(route));

   always #5 clk = ~clk;

   int    n_chk = 0, n_fail = 0;
   bit    done = 0;
   string req = "R11";
   logic [7:0] m [256];
   logic [7:0] e_rd;
   logic       e_bad, e_irq;

   function automatic bit is_rw(logic [7:0] a);
      return a inside {8'h50, 8'h52, 8'h54, [8'h98:8'h9F], 8'hE0, 8'hE4, 8'hE5};
   endfunction

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Reference model: one clock edge, then compare away from the edge.
   task automatic step();
      @(posedge clk);
      if (rst) begin
         foreach (m[i]) m[i] = 8'h00;
         e_rd = 8'h00; e_bad = 1'b0;
      end else begin
         e_bad = sel && !(is_rw(addr) || addr == 8'h08);
         e_rd  = 8'h00;
         if (sel && !wr) e_rd = (addr == 8'h08) ? REV : (is_rw(addr) ? m[addr] : 8'h00);
         if (sel && wr && is_rw(addr)) m[addr] = wdata;
         m[8'h50] = m[8'h50] | src;
      end
      e_irq = |(m[8'h50] & m[8'h52]);
      #1;
      chk("rdata", 32'(rdata), 32'(e_rd));
      chk("bad_access", 32'(bad), 32'(e_bad));
      chk("host_irq", 32'(irq), 32'(e_irq));
      chk("cfg_pll_a", plla, {m[8'h9F], m[8'h9E], m[8'h9D], m[8'h9C]});
      chk("cfg_16bit", {clkc, mode}, {m[8'h99], m[8'h98], m[8'hE5], m[8'hE4]});
      chk("cfg_8bit", {8'h00, pllb, route ^ fen}, {8'h00, m[8'h9B], m[8'h9A], m[8'h54] ^ m[8'hE0]});
   endtask

   task automatic acc(bit w, logic [7:0] a, logic [7:0] d);
      sel = 1'b1; wr = w; addr = a; wdata = d;
      step();
      sel = 1'b0; wr = 1'b0;
   endtask

   initial begin
      // R11: reset state
      repeat (3) step();
      rst = 1'b0;
      step();
      acc(0, 8'h08, 0); acc(0, 8'h98, 0);

      req = "R5";
      acc(1, 8'h52, 8'h00); acc(1, 8'h54, 8'hA5); acc(1, 8'hE0, 8'h3C);
      acc(0, 8'h54, 0); acc(0, 8'hE0, 0); acc(0, 8'h52, 0);

      req = "R2";
      acc(1, 8'h98, 8'h12); acc(1, 8'h99, 8'h34); acc(1, 8'h9A, 8'h56);
      acc(1, 8'h9B, 8'h78); acc(1, 8'hE4, 8'h9A); acc(1, 8'hE5, 8'hBC);
      for (int i = 0; i < 2; i++) begin
         acc(0, 8'h98 + 8'(i), 0); acc(0, 8'h9A + 8'(i), 0); acc(0, 8'hE4 + 8'(i), 0);
      end

      req = "R3";
      for (int i = 0; i < 4; i++) acc(1, 8'h9C + 8'(i), 8'h11 * 8'(i + 1));
      for (int i = 0; i < 4; i++) acc(0, 8'h9C + 8'(i), 0);

      req = "R4";
      acc(1, 8'h9E, 8'hFF); acc(1, 8'h99, 8'h00);
      for (int i = 0; i < 4; i++) acc(0, 8'h9C + 8'(i), 0);
      acc(0, 8'h98, 0);

      req = "R6";
      acc(1, 8'h08, 8'h00); acc(0, 8'h08, 0);

      req = "R7";
      src = 8'h05; step(); src = 8'h00; step(); step();
      acc(0, 8'h50, 0);

      req = "R9";
      acc(1, 8'h52, 8'h04); step();
      acc(1, 8'h52, 8'h02); step();
      acc(1, 8'h52, 8'hFF);

      req = "R8";
      src = 8'h01; acc(1, 8'h50, 8'h00); src = 8'h00;
      acc(0, 8'h50, 0);
      acc(1, 8'h50, 8'h00); acc(0, 8'h50, 0);
      acc(1, 8'h50, 8'h80); acc(0, 8'h50, 0);

      req = "R10";
      acc(0, 8'h51, 0); acc(0, 8'h00, 0); acc(0, 8'hFF, 0); acc(0, 8'hA0, 0);
      acc(1, 8'h51, 8'hFF); acc(1, 8'hA0, 8'h77); acc(1, 8'h53, 8'h00);
      acc(0, 8'h50, 0); acc(0, 8'h52, 0); acc(0, 8'h9F, 0);

      req = "R1";
      acc(0, 8'h9D, 0); acc(0, 8'h54, 0); step();

      req = "R11";
      rst = 1'b1; step(); rst = 1'b0;
      acc(0, 8'h9C, 0); acc(0, 8'h08, 0); acc(0, 8'h50, 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #200000ns;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule